// File: doc/BRIEF.md
# Turn and Hazard Lamp Sequencer

This block is a clocked Moore state machine that drives six rear lamps, three on each side. A turn request on one side lights that side's lamps one after another, working outwards over three clock ticks, and then switches every lamp off. A hazard request lights all six lamps for one tick and then clears them, so that a held hazard makes the whole set blink. A left and a right request raised together count as a hazard. With no request, every lamp stays dark.

The clock is expected to tick at the visible blink rate. Dividing a system clock down to that rate, and debouncing the switches, are left to the logic around the block. The lamps are decoded only from the registered state, so they change only on a clock edge. The current state code is also brought out, so that the surrounding logic can observe the sequence.

Top module: `tail_light_ctrl`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge puts the machine in the idle state: `phase_o` reads 3'b000 and all lamps are off from the next cycle.
- R2: `phase_o` shows the state as a three-bit code: idle 000, left steps one to three 001, 011, 010; right steps one to three 101, 111, 110; all-lamps flash 100.
- R3: In idle, with no request active, the machine stays in idle and every lamp is off.
- R4: In idle, a left request with no right request and no hazard walks the machine through left steps one, two and three, then back to idle. On `left_lamp_o`, bit 0 is the inner lamp and bit 2 the outer. These steps show 3'b001, 3'b011 and 3'b111 on `left_lamp_o`, and `right_lamp_o` stays 0.
- R5: A right request alone from idle mirrors R4 on the right side, through codes 101, 111 and 110 and `right_lamp_o` values 001, 011 and 111, with `left_lamp_o` held at 0.
- R6: In idle, an active hazard, or left and right requested together, moves the machine to the flash state. In that state both lamp outputs read 3'b111.
- R7: The flash state goes back to idle on the next tick whatever the inputs are.
- R8: An active hazard in left or right step one or two moves the machine straight to the flash state on the next tick.
- R9: Without a hazard, step one advances to step two and step two to step three on the same side whatever the turn inputs are. Step three always goes back to idle, even with a hazard active.
- R10: The lamp and state outputs change only at a clock edge. An input change between edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick per lamp step |
| rst_n | input | 1 | Synchronous reset, active low |
| turn_left_i | input | 1 | Left turn request |
| turn_right_i | input | 1 | Right turn request |
| hazard_i | input | 1 | Hazard request |
| left_lamp_o | output | 3 | Left lamps, bit 0 inner, bit 2 outer |
| right_lamp_o | output | 3 | Right lamps, bit 0 inner, bit 2 outer |
| phase_o | output | 3 | Registered state code |

## Verification
The hardest case to reach is a hazard that arrives part way through a turn sequence. A hazard can only cut in at step one or step two, and those states exist for a single tick each. The stimulus resets the machine and replays the exact request pattern that lands it in each of the eight states. It then applies every one of the eight input combinations for one tick. After that tick it compares the next state and the lamps with a model written from the transition rules. This covers the cut-in from every turn step and the cases where a hazard is ignored at step three.

// File: rtl/tl_pkg.sv
package tl_pkg;
    localparam int LAMPS_PER_SIDE = 3;
    localparam int STEP_W = $clog2(LAMPS_PER_SIDE + 1);
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'b000,
        ST_L1    = 3'b001,
        ST_L2    = 3'b011,
        ST_L3    = 3'b010,
        ST_R1    = 3'b101,
        ST_R2    = 3'b111,
        ST_R3    = 3'b110,
        ST_FLASH = 3'b100
    } tl_state_e;

    typedef struct packed {
        tl_state_e state;
    } tl_regs_t;

    typedef struct packed {
        logic left;
        logic right;
        logic hazard;
    } tl_req_t;
endpackage

// File: rtl/tl_next.sv
module tl_next
    import tl_pkg::*;
(
    input  tl_state_e cur_i,
    input  tl_req_t   req_i,
    output tl_state_e nxt_o
);
    logic flash_req;
    logic cut_in;

    always_comb begin
        flash_req = req_i.hazard | (req_i.left & req_i.right);
        cut_in    = req_i.hazard;
        nxt_o     = ST_IDLE;
        unique case (cur_i)
            ST_IDLE: begin
                if (flash_req)         nxt_o = ST_FLASH;
                else if (req_i.left)   nxt_o = ST_L1;
                else if (req_i.right)  nxt_o = ST_R1;
                else                   nxt_o = ST_IDLE;
            end
            ST_L1:    nxt_o = cut_in ? ST_FLASH : ST_L2;
            ST_L2:    nxt_o = cut_in ? ST_FLASH : ST_L3;
            ST_L3:    nxt_o = ST_IDLE;
            ST_R1:    nxt_o = cut_in ? ST_FLASH : ST_R2;
            ST_R2:    nxt_o = cut_in ? ST_FLASH : ST_R3;
            ST_R3:    nxt_o = ST_IDLE;
            ST_FLASH: nxt_o = ST_IDLE;
            default:  nxt_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tl_pkg::*;
(
    input  tl_state_e                 state_i,
    output logic [LAMPS_PER_SIDE-1:0] left_o,
    output logic [LAMPS_PER_SIDE-1:0] right_o
);
    logic [STEP_W-1:0] left_steps;
    logic [STEP_W-1:0] right_steps;

    always_comb begin
        left_steps  = '0;
        right_steps = '0;
        unique case (state_i)
            ST_L1:    left_steps = STEP_W'(1);
            ST_L2:    left_steps = STEP_W'(2);
            ST_L3:    left_steps = STEP_W'(3);
            ST_R1:    right_steps = STEP_W'(1);
            ST_R2:    right_steps = STEP_W'(2);
            ST_R3:    right_steps = STEP_W'(3);
            ST_FLASH: begin
                left_steps  = STEP_W'(LAMPS_PER_SIDE);
                right_steps = STEP_W'(LAMPS_PER_SIDE);
            end
            default: begin
                left_steps  = '0;
                right_steps = '0;
            end
        endcase
    end

    for (genvar i = 0; i < LAMPS_PER_SIDE; i++) begin : g_lamp
        assign left_o[i]  = (left_steps  > STEP_W'(i));
        assign right_o[i] = (right_steps > STEP_W'(i));
    end
endmodule

// File: rtl/tail_light_ctrl.sv
module tail_light_ctrl
    import tl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       turn_left_i,
    input  logic       turn_right_i,
    input  logic       hazard_i,
    output logic [2:0] left_lamp_o,
    output logic [2:0] right_lamp_o,
    output logic [2:0] phase_o
);
    tl_regs_t  regs_d;
    tl_regs_t  regs_q;
    tl_req_t   req;
    tl_state_e step_nxt;

    assign req = '{left: turn_left_i, right: turn_right_i, hazard: hazard_i};

    tl_next next_i (
        .cur_i (regs_q.state),
        .req_i (req),
        .nxt_o (step_nxt)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = step_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{state: ST_IDLE};
        else        regs_q <= regs_d;
    end

    tl_lamp_decode decode_i (
        .state_i (regs_q.state),
        .left_o  (left_lamp_o),
        .right_o (right_lamp_o)
    );

    assign phase_o = regs_q.state;

    // R8
    hazard_cut_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_i && (phase_o inside {3'b001, 3'b011, 3'b101, 3'b111}))
        |=> (phase_o == 3'b100));

    // R7
    flash_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'b100) |=> (phase_o == 3'b000));

    // R9
    last_step_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o inside {3'b010, 3'b110}) |=> (phase_o == 3'b000));

    // R6
    sides_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((left_lamp_o != 3'b000) && (right_lamp_o != 3'b000))
        |-> ((left_lamp_o == 3'b111) && (right_lamp_o == 3'b111)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_o == 3'b000) && !turn_left_i && !turn_right_i && !hazard_i)
        |=> ((phase_o == 3'b000) && (left_lamp_o == 3'b000) && (right_lamp_o == 3'b000)));

    // R10
    outputs_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(phase_o) |-> ($stable(left_lamp_o) && $stable(right_lamp_o)));
endmodule

// File: tb/tail_light_ctrl_tb_top.sv
`timescale 1ns/1ps
module tail_light_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lft = 1'b0, rgt = 1'b0, haz = 1'b0;
    logic [2:0] left_lamp, right_lamp, phase;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tail_light_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .turn_left_i(lft), .turn_right_i(rgt),
        .hazard_i(haz), .left_lamp_o(left_lamp), .right_lamp_o(right_lamp),
        .phase_o(phase)
    );

    function automatic logic [2:0] model_next(input logic [2:0] s, input logic l,
                                              input logic r, input logic h);
        case (s)
            3'b000: model_next = (h || (l && r)) ? 3'b100 : l ? 3'b001 : r ? 3'b101 : 3'b000;
            3'b001: model_next = h ? 3'b100 : 3'b011;
            3'b011: model_next = h ? 3'b100 : 3'b010;
            3'b101: model_next = h ? 3'b100 : 3'b111;
            3'b111: model_next = h ? 3'b100 : 3'b110;
            default: model_next = 3'b000;
        endcase
    endfunction

    function automatic logic [5:0] model_lamps(input logic [2:0] s);
        case (s)
            3'b001: model_lamps = {3'b001, 3'b000};
            3'b011: model_lamps = {3'b011, 3'b000};
            3'b010: model_lamps = {3'b111, 3'b000};
            3'b101: model_lamps = {3'b000, 3'b001};
            3'b111: model_lamps = {3'b000, 3'b011};
            3'b110: model_lamps = {3'b000, 3'b111};
            3'b100: model_lamps = {3'b111, 3'b111};
            default: model_lamps = 6'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick(input logic l, input logic r, input logic h);
        lft = l; rgt = r; haz = h;
        @(posedge clk);
        #1;
    endtask

    task automatic reach(input logic [2:0] target);
        rst_n = 1'b0;
        tick(0, 0, 0);
        rst_n = 1'b1;
        case (target)
            3'b001: tick(1, 0, 0);
            3'b011: begin tick(1, 0, 0); tick(0, 0, 0); end
            3'b010: begin tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0); end
            3'b101: tick(0, 1, 0);
            3'b111: begin tick(0, 1, 0); tick(0, 0, 0); end
            3'b110: begin tick(0, 1, 0); tick(0, 0, 0); tick(0, 0, 0); end
            3'b100: tick(0, 0, 1);
            default: ;
        endcase
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] s_list [8] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b101, 3'b111, 3'b110, 3'b100};
        // R1 reset state
        tick(1, 0, 0);
        tick(0, 0, 0);
        check("R1", {phase, left_lamp, right_lamp}, 9'b0);
        rst_n = 1'b1;
        // R4 left sequence
        tick(1, 0, 0); check("R4 step1", {phase, left_lamp, right_lamp}, {3'b001, 3'b001, 3'b000});
        tick(1, 0, 0); check("R4 step2", {phase, left_lamp, right_lamp}, {3'b011, 3'b011, 3'b000});
        tick(1, 0, 0); check("R4 step3", {phase, left_lamp, right_lamp}, {3'b010, 3'b111, 3'b000});
        tick(0, 0, 0); check("R4 end", {phase, left_lamp, right_lamp}, 9'b0);
        // R5 right sequence
        tick(0, 1, 0); check("R5 step1", {phase, left_lamp, right_lamp}, {3'b101, 3'b000, 3'b001});
        tick(0, 0, 0); check("R5 step2", {phase, left_lamp, right_lamp}, {3'b111, 3'b000, 3'b011});
        tick(0, 0, 0); check("R5 step3", {phase, left_lamp, right_lamp}, {3'b110, 3'b000, 3'b111});
        tick(0, 0, 0); check("R5 end", {phase, left_lamp, right_lamp}, 9'b0);
        // R6 / R7 held hazard blinks
        tick(0, 0, 1); check("R6 flash", {phase, left_lamp, right_lamp}, {3'b100, 6'b111111});
        tick(0, 0, 1); check("R7 off", {phase, left_lamp, right_lamp}, 9'b0);
        tick(1, 1, 0); check("R6 both", {phase, left_lamp, right_lamp}, {3'b100, 6'b111111});
        tick(1, 1, 0); check("R7 both", {phase, left_lamp, right_lamp}, 9'b0);
        // R3 idle hold
        tick(0, 0, 0); check("R3", {phase, left_lamp, right_lamp}, 9'b0);
        // R10 mid-cycle input change
        #1; lft = 1'b1; haz = 1'b1; #1;
        check("R10", {phase, left_lamp, right_lamp}, 9'b0);
        // R2 R8 R9 sweep: every state, every input combination
        foreach (s_list[k]) begin
            for (int c = 0; c < 8; c++) begin
                logic [2:0] e;
                reach(s_list[k]);
                check("R2 reach", {phase, 6'b0}, {s_list[k], 6'b0});
                e = model_next(s_list[k], c[2], c[1], c[0]);
                tick(c[2], c[1], c[0]);
                if (s_list[k] inside {3'b001, 3'b011, 3'b101, 3'b111} && c[0])
                    check("R8", {phase, left_lamp, right_lamp}, {e, model_lamps(e)});
                else
                    check("R9", {phase, left_lamp, right_lamp}, {e, model_lamps(e)});
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule